// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel flash. Every bus write, already synchronised into a single-cycle strobe carrying a 19-bit address and a data byte, is offered to the decoder. The decoder follows the multi-write command protocol. Every command opens with the same two-write unlock handshake. Depending on what follows, the protocol is three, four or six writes long, and boot locking needs one further write. The decoder returns to read mode on any write that does not fit the expected step.

When a sequence completes, the decoder raises one single-cycle request to the program/erase engine. The request carries the command code and the address and data that the engine needs. The decoder also holds a flag that tells the read path to return identification bytes instead of array data. While the engine reports busy, the decoder deasserts ready and discards offered writes. A discarded write does not advance a sequence and does not break it.

Input side rules: a write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. The source does not hold a write that is refused, so back-pressure drops writes rather than stalling them. The request side has no ready and is a pulse that the engine must capture.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the decoder is in read mode, `req_valid` and `id_mode` are 0, `req_op` is 0 (none), and `wr_ready` equals the inverse of `eng_busy`.
- R2: Unlock and command-register writes compare only address bits 14:0. The first unlock write is 0xAA to 0x5555 and the second is 0x55 to 0x2AAA. Address bits 18:15 have no effect on these steps.
- R3: Unlock, then 0xA0 to 0x5555, then any write W gives a request with `req_op`=1 (program), `req_addr`/`req_data` equal to the address and data of W.
- R4: Unlock, 0x80 to 0x5555, unlock again, then 0x10 to 0x5555 gives `req_op`=2 (chip erase) with the final write's address and data.
- R5: In the same six-write form, a final byte of 0x30 to any address gives `req_op`=3 (sector erase) and 0x50 to any address gives `req_op`=4 (page erase). Both carry the final write's full address and data.
- R6: In the six-write form, a final byte of 0x40 or 0x70 to 0x5555 arms a boot lock. The next write to 0x7FFFF or 0x00000 (all 19 bits compared, any data) gives `req_op`=5 (lock). `req_addr` is that address and `req_data` is the armed byte (0x40 for 64 KB, 0x70 for 16 KB). A write to any other address gives no request.
- R7: Unlock followed by 0x90 to 0x5555 gives `req_op`=6 (ID entry) and sets `id_mode`. Either unlock followed by 0xF0 to 0x5555, or a single 0xF0 written to any address while in read mode, gives `req_op`=7 (ID exit) and clears `id_mode`.
- R8: A write with the wrong address or data at any step after the first returns the decoder to read mode with no request. That write is not also taken as the start of a new sequence.
- R9: While `eng_busy` is high, `wr_ready` is low. Offered writes are dropped, give no request, and leave the sequence position unchanged.
- R10: Each completed command gives exactly one request, high for exactly one cycle, visible in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A bus write is offered this cycle |
| wr_ready | output | 1 | Writes are accepted (engine idle) |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data byte |
| eng_busy | input | 1 | Program/erase engine is running |
| req_valid | output | 1 | Single-cycle command request |
| req_op | output | 3 | Command code: 0 none, 1 program, 2 chip erase, 3 sector erase, 4 page erase, 5 lock, 6 ID entry, 7 ID exit |
| req_addr | output | 19 | Address carried with the request |
| req_data | output | 8 | Data byte carried with the request |
| id_mode | output | 1 | Identification read mode is active |

## Verification
The assertions assume that `wr_addr` and `wr_data` matter only in cycles where `wr_valid` is high. They also assume that `eng_busy` is a level the engine may change in any cycle, independent of the requests. The stimulus offers each write for exactly one cycle and idles for one cycle between writes, so every request can be seen on its own. Busy is raised and dropped only between writes, and some writes are offered while it is high.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int ADDR_W  = 19;
  localparam int DATA_W  = 8;
  localparam int CMP_W   = 15;

  localparam int unsigned KEY1_ADDR = 'h5555;
  localparam int unsigned KEY2_ADDR = 'h2AAA;

  // indices into the data-code hit vector
  localparam int C_AA   = 0;
  localparam int C_55   = 1;
  localparam int C_PROG = 2;
  localparam int C_ERS  = 3;
  localparam int C_IDIN = 4;
  localparam int C_IDX  = 5;
  localparam int C_CHIP = 6;
  localparam int C_SECT = 7;
  localparam int C_PAGE = 8;
  localparam int C_L64  = 9;
  localparam int C_L16  = 10;
  localparam int NCODE  = 11;

  function automatic logic [DATA_W-1:0] code_of(input int idx);
    case (idx)
      C_AA:    code_of = 8'hAA;
      C_55:    code_of = 8'h55;
      C_PROG:  code_of = 8'hA0;
      C_ERS:   code_of = 8'h80;
      C_IDIN:  code_of = 8'h90;
      C_IDX:   code_of = 8'hF0;
      C_CHIP:  code_of = 8'h10;
      C_SECT:  code_of = 8'h30;
      C_PAGE:  code_of = 8'h50;
      C_L64:   code_of = 8'h40;
      C_L16:   code_of = 8'h70;
      default: code_of = 8'h00;
    endcase
  endfunction

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PROGRAM  = 3'd1,
    OP_CHIP     = 3'd2,
    OP_SECTOR   = 3'd3,
    OP_PAGE     = 3'd4,
    OP_LOCK     = 3'd5,
    OP_ID_ENTER = 3'd6,
    OP_ID_EXIT  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_READ, S_UNL1, S_UNL2, S_PROG, S_ERS1, S_ERS2, S_ERS3, S_LOCK
  } seq_e;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CMP_W
) (
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  output logic             at_key1,
  output logic             at_key2,
  output logic             at_top,
  output logic             at_bottom,
  output logic [NCODE-1:0] dhit
);

  localparam logic [CW-1:0] K1 = CW'(KEY1_ADDR);
  localparam logic [CW-1:0] K2 = CW'(KEY2_ADDR);

  // command-register addresses look at the low bits only
  assign at_key1   = (addr[CW-1:0] == K1);
  assign at_key2   = (addr[CW-1:0] == K2);
  // boot-lock targets are decoded over the whole address
  assign at_top    = (addr == {AW{1'b1}});
  assign at_bottom = (addr == {AW{1'b0}});

  for (genvar i = 0; i < NCODE; i++) begin : g_code
    assign dhit[i] = (data == DW'(code_of(i)));
  end

  always_comb begin
    assert (!(at_key1 && at_key2)) else $error("p_keys_exclusive_r2");
    assert ($countones(dhit) <= 1) else $error("p_one_code_r8");
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             at_key1,
  input  logic             at_key2,
  input  logic             at_top,
  input  logic             at_bottom,
  input  logic [NCODE-1:0] dhit,
  output op_e              hit_op,
  output logic             use_lock_code,
  output logic [DW-1:0]    lock_code
);

  seq_e state, nxt;
  logic lk16_q;

  always_comb begin
    nxt    = state;
    hit_op = OP_NONE;
    case (state)
      S_READ: begin
        if (at_key1 && dhit[C_AA]) nxt = S_UNL1;
        else if (dhit[C_IDX])      hit_op = OP_ID_EXIT;
      end
      S_UNL1: nxt = (at_key2 && dhit[C_55]) ? S_UNL2 : S_READ;
      S_UNL2: begin
        nxt = S_READ;
        if (at_key1) begin
          if (dhit[C_PROG])      nxt = S_PROG;
          else if (dhit[C_ERS])  nxt = S_ERS1;
          else if (dhit[C_IDIN]) hit_op = OP_ID_ENTER;
          else if (dhit[C_IDX])  hit_op = OP_ID_EXIT;
        end
      end
      S_PROG: begin
        nxt    = S_READ;
        hit_op = OP_PROGRAM;
      end
      S_ERS1: nxt = (at_key1 && dhit[C_AA]) ? S_ERS2 : S_READ;
      S_ERS2: nxt = (at_key2 && dhit[C_55]) ? S_ERS3 : S_READ;
      S_ERS3: begin
        nxt = S_READ;
        if (dhit[C_SECT])      hit_op = OP_SECTOR;
        else if (dhit[C_PAGE]) hit_op = OP_PAGE;
        else if (at_key1) begin
          if (dhit[C_CHIP])                    hit_op = OP_CHIP;
          else if (dhit[C_L64] || dhit[C_L16]) nxt = S_LOCK;
        end
      end
      S_LOCK: begin
        nxt = S_READ;
        if (at_top || at_bottom) hit_op = OP_LOCK;
      end
      default: nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_READ;
      lk16_q <= 1'b0;
    end else if (fire) begin
      state <= nxt;
      if (state == S_ERS3) lk16_q <= dhit[C_L16];
    end
  end

  assign use_lock_code = (state == S_LOCK);
  assign lock_code     = lk16_q ? DW'(code_of(C_L16)) : DW'(code_of(C_L64));

  // R9: nothing moves without an accepted write
  p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(state));

  // R8: a write taken mid-sequence never restarts the unlock handshake
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && state != S_READ) |=> state != S_UNL1);

  // R6: the lock step is reached only from the final erase-form step
  p_lock_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOCK && !$stable(state)) |-> $past(state) == S_ERS3);

endmodule

// File: rtl/fcd_issue.sv
module fcd_issue
  import fcd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  op_e           hit_op,
  input  logic          use_lock_code,
  input  logic [DW-1:0] lock_code,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          req_valid,
  output op_e           req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          id_mode
);

  logic issue;
  assign issue = fire && (hit_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_op    <= OP_NONE;
      req_addr  <= '0;
      req_data  <= '0;
      id_mode   <= 1'b0;
    end else begin
      req_valid <= issue;
      req_op    <= issue ? hit_op : OP_NONE;
      if (issue) begin
        req_addr <= addr;
        req_data <= use_lock_code ? lock_code : data;
        if (hit_op == OP_ID_ENTER) id_mode <= 1'b1;
        if (hit_op == OP_ID_EXIT)  id_mode <= 1'b0;
      end
    end
  end

  // R10: code is present exactly when the pulse is
  p_op_with_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == (req_op != OP_NONE));

  // R7: mode changes only alongside the matching request
  p_id_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> (req_valid && req_op == OP_ID_ENTER));
  p_id_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> (req_valid && req_op == OP_ID_EXIT));

  // R6: a lock request carries one of the two size codes
  p_lock_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_LOCK) |-> (req_data == 8'h40 || req_data == 8'h70));

  // R4: chip erase carries its command byte
  p_chip_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_CHIP) |-> req_data == 8'h10);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_busy,
  output logic          req_valid,
  output logic [2:0]    req_op,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          id_mode
);

  logic             fire;
  logic             at_key1, at_key2, at_top, at_bottom;
  logic [NCODE-1:0] dhit;
  op_e              hit_op;
  op_e              op_q;
  logic             use_lock_code;
  logic [DW-1:0]    lock_code;

  assign wr_ready = !eng_busy;
  assign fire     = wr_valid && wr_ready;

  fcd_match #(.AW(AW), .DW(DW), .CW(CW)) u_match (
    .addr      (wr_addr),
    .data      (wr_data),
    .at_key1   (at_key1),
    .at_key2   (at_key2),
    .at_top    (at_top),
    .at_bottom (at_bottom),
    .dhit      (dhit)
  );

  fcd_seq #(.DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .at_key1       (at_key1),
    .at_key2       (at_key2),
    .at_top        (at_top),
    .at_bottom     (at_bottom),
    .dhit          (dhit),
    .hit_op        (hit_op),
    .use_lock_code (use_lock_code),
    .lock_code     (lock_code)
  );

  fcd_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .hit_op        (hit_op),
    .use_lock_code (use_lock_code),
    .lock_code     (lock_code),
    .addr          (wr_addr),
    .data          (wr_data),
    .req_valid     (req_valid),
    .req_op        (op_q),
    .req_addr      (req_addr),
    .req_data      (req_data),
    .id_mode       (id_mode)
  );

  assign req_op = op_q;

  // R1: quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) assert (!req_valid && !id_mode) else $error("p_quiet_in_reset_r1");
  end

  // R10: every pulse follows an accepted write
  p_req_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wr_valid && wr_ready));

  // R9: a busy engine cannot be handed a request
  p_busy_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_busy) |-> !req_valid);

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        eng_busy = 1'b0;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [18:0] req_addr;
  logic [7:0]  req_data;
  logic        id_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        g_v;
  logic [2:0]  g_op;
  logic [18:0] g_a;
  logic [7:0]  g_d;

  always #2 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .eng_busy(eng_busy),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .id_mode(id_mode)
  );

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    g_v = req_valid; g_op = req_op; g_a = req_addr; g_d = req_data;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // op 0 means no request expected after the last write
  task automatic expect_req(input string tag, input logic [2:0] op,
                            input logic [18:0] a, input logic [7:0] d);
    if (op == 3'd0) begin
      check(!g_v, tag, {31'd0, g_v}, 32'd0);
    end else begin
      check(g_v && g_op == op, tag, {g_v, 28'd0, g_op}, {1'b1, 28'd0, op});
      check(g_a == a && g_d == d, tag, {5'd0, g_a, g_d}, {5'd0, a, d});
      @(negedge clk);
      check(!req_valid, {tag, " R10 width"}, {31'd0, req_valid}, 32'd0);
    end
  endtask

  task automatic unlock(input logic [3:0] hi1, input logic [3:0] hi2);
    wr({hi1, 15'h5555}, 8'hAA);
    wr({hi2, 15'h2AAA}, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!req_valid && !id_mode && req_op == 3'd0, "R1 reset outputs",
          {29'd0, req_valid, id_mode, 1'b0}, 32'd0);
    check(wr_ready == 1'b1, "R1 ready", {31'd0, wr_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_valid && !id_mode, "R1 after release", {30'd0, req_valid, id_mode}, 32'd0);

    // R2 + R7: prefix with every upper-bit pattern, entry then single-write exit
    for (int hi = 0; hi < 16; hi++) begin
      unlock(4'(hi), 4'(15 - hi));
      wr({4'(hi ^ 5), 15'h5555}, 8'h90);
      expect_req("R2 R7 enter", 3'd6, {4'(hi ^ 5), 15'h5555}, 8'h90);
      check(id_mode, "R7 id set", {31'd0, id_mode}, 32'd1);
      wr(19'(hi * 4099 + 7), 8'hF0);
      expect_req("R7 single exit", 3'd7, 19'(hi * 4099 + 7), 8'hF0);
      check(!id_mode, "R7 id clear", {31'd0, id_mode}, 32'd0);
    end

    // R7: three-write exit
    unlock(0, 0); wr(19'h05555, 8'h90);
    unlock(0, 0); wr(19'h45555, 8'hF0);
    expect_req("R7 prefixed exit", 3'd7, 19'h45555, 8'hF0);
    check(!id_mode, "R7 id clear 3w", {31'd0, id_mode}, 32'd0);

    // third-write data sweep: R3, R4, R7, R8
    for (int d = 0; d < 256; d++) begin
      unlock(4'(d), 4'(d >> 4));
      wr(19'h05555, 8'(d));
      if (d == 'h90)      expect_req("R7 sweep enter", 3'd6, 19'h05555, 8'(d));
      else if (d == 'hF0) expect_req("R7 sweep exit", 3'd7, 19'h05555, 8'(d));
      else                expect_req("R8 sweep step3", 3'd0, 0, 0);
      if (d == 'hA0) begin
        wr(19'(d * 1777 + 3), 8'(~d));
        expect_req("R3 program", 3'd1, 19'(d * 1777 + 3), 8'(~d));
      end else if (d == 'h80) begin
        unlock(4'(d), 0);
        wr(19'h35555, 8'h10);
        expect_req("R4 chip erase", 3'd2, 19'h35555, 8'h10);
      end
    end
    wr(0, 8'hF0); // leave id mode

    // final erase byte sweep: R4, R5, R6, R8
    for (int d = 0; d < 256; d++) begin
      logic [18:0] fa;
      fa = {4'(d), 15'h5555};
      unlock(0, 0); wr(19'h05555, 8'h80); unlock(0, 0);
      wr(fa, 8'(d));
      if (d == 'h10)      expect_req("R4 sweep chip", 3'd2, fa, 8'(d));
      else if (d == 'h30) expect_req("R5 sector", 3'd3, fa, 8'(d));
      else if (d == 'h50) expect_req("R5 page", 3'd4, fa, 8'(d));
      else if (d == 'h40 || d == 'h70) begin
        logic [18:0] la;
        expect_req("R6 armed", 3'd0, 0, 0);
        la = d[0] ? 19'h7FFFF : 19'h00000;
        wr(la, 8'h5A);
        expect_req("R6 lock", 3'd5, la, 8'(d));
        // sector/page with address bits away from the key
        unlock(0, 0); wr(19'h05555, 8'h80); unlock(0, 0);
        wr(19'h61234, 8'h30);
        expect_req("R5 sector any addr", 3'd3, 19'h61234, 8'h30);
        unlock(0, 0); wr(19'h05555, 8'h80); unlock(0, 0);
        wr(19'h2ABCD, 8'h50);
        expect_req("R5 page any addr", 3'd4, 19'h2ABCD, 8'h50);
        unlock(0, 0); wr(19'h05555, 8'h80); unlock(0, 0);
        wr(19'h05555, 8'(d));
        wr(19'h40000, 8'h00);
        expect_req("R6 wrong lock addr", 3'd0, 0, 0);
        wr(19'h7FFFF, 8'h00);
        expect_req("R6 lock not pending", 3'd0, 0, 0);
      end else begin
        expect_req("R8 sweep step6", 3'd0, 0, 0);
        if (d == 'hF0) wr(0, 8'h00);
      end
    end
    check(!id_mode, "R7 idle mode", {31'd0, id_mode}, 32'd0);

    // R8 wrong steps
    wr(19'h05554, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
    expect_req("R8 bad first addr", 3'd0, 0, 0);
    wr(19'h05555, 8'hAA); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'h90);
    expect_req("R8 no restart", 3'd0, 0, 0);
    check(!id_mode, "R8 no entry", {31'd0, id_mode}, 32'd0);
    wr(19'h05555, 8'hAA); wr(19'h01234, 8'hF0);
    expect_req("R8 exit byte mid-prefix", 3'd0, 0, 0);
    unlock(0, 0); wr(19'h05556, 8'h90);
    expect_req("R8 bad step3 addr", 3'd0, 0, 0);
    unlock(0, 0); wr(19'h05555, 8'h80); wr(19'h05555, 8'h55);
    wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h10);
    expect_req("R8 bad erase unlock", 3'd0, 0, 0);

    // R9 busy drop
    unlock(0, 0);
    @(negedge clk); eng_busy = 1'b1;
    @(negedge clk);
    check(!wr_ready, "R9 ready low", {31'd0, wr_ready}, 32'd0);
    wr(19'h01234, 8'h12);
    expect_req("R9 dropped garbage", 3'd0, 0, 0);
    wr(19'h00000, 8'hF0);
    expect_req("R9 dropped exit", 3'd0, 0, 0);
    eng_busy = 1'b0;
    wr(19'h05555, 8'hA0);
    wr(19'h2468A, 8'h3C);
    expect_req("R9 sequence kept", 3'd1, 19'h2468A, 8'h3C);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule